// File: doc/BRIEF.md
# Memory-Mapped Dual Parallel Port

This peripheral exposes two byte-wide ports to a simple memory bus. The data port is bidirectional. As an output it drives eight pins and, through a gate, a bank of LEDs. As an input it samples eight external pins through a synchronizer so that software can read them. The control port holds the settings that govern the data port: its direction and whether the LEDs are lit. It also holds two static lines for a character display, a register-select line and an enable strobe.

Software sets the control port first and then writes or reads the data port. For example, a store of 0x10 to the control port followed by a store of 0xA5 to the data port shows the pattern 0xA5 on the LEDs. The bus uses single-cycle byte write and read strobes. Read data is combinational and is zero when no read is in progress.

Top module: `pp_dual_port`

## Requirements
- R1: During and after reset, both latches are zero: `pa_out`, `pa_oe`, `led`, `disp_rs` and `disp_en` are all 0, and a read of the control port returns 0x00.
- R2: A write at byte offset 0x04 loads the control latch on the next clock edge. A read there returns the latch with bits 3, 5, 6 and 7 forced to 0, so the readback is `wdata & 0x17`.
- R3: Control bit 2 sets the direction. When it is 1, `pa_oe` is 0xFF; when it is 0, `pa_oe` is 0x00. A write at offset 0x00 loads the data latch, and `pa_out` always drives that latch.
- R4: Control bit 4 enables the LEDs. When it is 1, `led` equals the data latch; when it is 0, `led` is 0x00.
- R5: `disp_rs` follows control bit 1 and `disp_en` follows control bit 0.
- R6: When bit 2 is 1, a read at offset 0x00 returns the data latch, not the external pins.
- R7: When bit 2 is 0, a read at offset 0x00 returns `pa_in` as it was two clock edges earlier, so a change on `pa_in` is invisible after one edge and visible after two.
- R8: A read at any offset other than 0x00 or 0x04 returns 0x00. A write there changes no latch, so every output keeps its value.
- R9: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both latches and the synchronizer |
| bus_addr | input | 8 | Byte offset inside the peripheral window |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Byte read strobe |
| bus_rdata | output | 8 | Read data (combinational, 0 when idle) |
| pa_in | input | 8 | Data-port pins as seen from outside |
| pa_out | output | 8 | Data-port output latch to the pins |
| pa_oe | output | 8 | Per-pin output enable of the data port |
| led | output | 8 | LED drive |
| disp_rs | output | 1 | Display register-select line |
| disp_en | output | 1 | Display enable strobe |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that `pa_in` is stable around the sampling clock edge, so that a two-edge-old value is well defined. The stimulus drives every bus signal and `pa_in` only at the falling clock edge, and it issues writes and reads as separate one-cycle strobes. The synchronizer-latency property is checked only once two clean edges have passed since reset. A counter in the checker enforces this, so pre-reset pin values never reach it.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // control-latch bit positions; the data port and the display decode these
  localparam int CB_DISP_EN = 0;
  localparam int CB_DISP_RS = 1;
  localparam int CB_DIR_OUT = 2;
  localparam int CB_LED_ON  = 4;
  localparam logic [7:0] CTRL_MASK = 8'h17;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;

  // keep only implemented control bits
  function automatic logic [7:0] ctrl_keep(input logic [7:0] d);
    return d & CTRL_MASK;
  endfunction

  // gated LED drive
  function automatic logic [7:0] led_gate(input logic en, input logic [7:0] d);
    return en ? d : 8'h00;
  endfunction
endpackage

// File: rtl/pp_bus_decode.sv
module pp_bus_decode
  import pp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output sel_e              sel,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              rd_any
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  always_comb begin
    if (addr == A_DATA)      sel = SEL_DATA;
    else if (addr == A_CTRL) sel = SEL_CTRL;
    else                     sel = SEL_NONE;
  end

  assign wr_data = wr && (sel == SEL_DATA);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign rd_any  = rd;
endmodule

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pp_ctrl_port.sv
module pp_ctrl_port
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl,
  output logic       dir_out,
  output logic       led_on,
  output logic       disp_rs,
  output logic       disp_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl <= 8'h00;
    else if (we) ctrl <= ctrl_keep(wdata);
  end

  assign dir_out = ctrl[CB_DIR_OUT];
  assign led_on  = ctrl[CB_LED_ON];
  assign disp_rs = ctrl[CB_DISP_RS];
  assign disp_en = ctrl[CB_DISP_EN];
endmodule

// File: rtl/pp_data_port.sv
module pp_data_port
  import pp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         dir_out,
  input  logic         led_on,
  input  logic [W-1:0] pins_sync,
  output logic [W-1:0] latch,
  output logic [W-1:0] oe,
  output logic [W-1:0] led,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  latch <= '0;
    else if (we) latch <= wdata;
  end

  assign oe     = {W{dir_out}};
  assign led    = led_gate(led_on, latch);
  assign rd_val = dir_out ? latch : pins_sync;
endmodule

// File: rtl/pp_dual_port.sv
module pp_dual_port
  import pp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_OFS    = 0,
  parameter int CTRL_OFS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pa_in,
  output logic [7:0]        pa_out,
  output logic [7:0]        pa_oe,
  output logic [7:0]        led,
  output logic              disp_rs,
  output logic              disp_en
);
  sel_e       sel;
  logic       wr_data_evt, wr_ctrl_evt, rd_evt;
  logic [7:0] ctrl_q, pins_q, data_rd;
  logic       dir_out, led_on;

  pp_bus_decode #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .wr_data(wr_data_evt), .wr_ctrl(wr_ctrl_evt), .rd_any(rd_evt)
  );

  pp_sync #(.W(8), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pa_in), .q(pins_q)
  );

  pp_ctrl_port u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(wr_ctrl_evt), .wdata(bus_wdata),
    .ctrl(ctrl_q), .dir_out(dir_out), .led_on(led_on),
    .disp_rs(disp_rs), .disp_en(disp_en)
  );

  pp_data_port #(.W(8)) u_data (
    .clk(clk), .rst_n(rst_n), .we(wr_data_evt), .wdata(bus_wdata),
    .dir_out(dir_out), .led_on(led_on), .pins_sync(pins_q),
    .latch(pa_out), .oe(pa_oe), .led(led), .rd_val(data_rd)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_evt) begin
      unique case (sel)
        SEL_DATA: bus_rdata = data_rd;
        SEL_CTRL: bus_rdata = ctrl_q;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pp_dual_port_checker.sv
module pp_dual_port_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pa_in,
  input logic [7:0]        pa_out,
  input logic [7:0]        pa_oe,
  input logic [7:0]        led,
  input logic              disp_rs,
  input logic              disp_en,
  input logic              wr_ctrl_evt
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic       undecoded;
  logic [1:0] since_rst;
  assign undecoded = (bus_addr != A_DATA) && (bus_addr != A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_oe_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_evt |=> (pa_oe == {8{$past(bus_wdata[2])}}));
  p_oe_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == 8'h00) || (pa_oe == 8'hFF));
  p_led_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (led != 8'h00) |-> (led == pa_out));
  p_disp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_evt |=> (disp_rs == $past(bus_wdata[1])) && (disp_en == $past(bus_wdata[0])));
  p_out_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && pa_oe == 8'hFF) |-> (bus_rdata == pa_out));
  p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_rd && bus_addr == A_DATA && pa_oe == 8'h00)
      |-> (bus_rdata == $past(pa_in, 2)));
  p_undec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && undecoded) |=> $stable(pa_out) && $stable(pa_oe) && $stable(led)
                              && $stable(disp_rs) && $stable(disp_en));
  p_undec_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && undecoded) |-> (bus_rdata == 8'h00));
  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind pp_dual_port pp_dual_port_checker #(
  .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .led(led),
  .disp_rs(disp_rs), .disp_en(disp_en), .wr_ctrl_evt(wr_ctrl_evt)
);

// File: tb/test_pp_dual_port.sv
`timescale 1ns/1ps
module test_pp_dual_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h00;
  logic [7:0] pa_out, pa_oe, led;
  logic       disp_rs, disp_en;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  pp_dual_port i_pp_dual_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .led(led),
    .disp_rs(disp_rs), .disp_en(disp_en)
  );

  // {offset, wdata, exp_pa_out, exp_led, exp_oe, exp_rs, exp_en}
  typedef struct packed {
    logic [7:0] ofs;
    logic [7:0] wd;
    logic [7:0] e_pa;
    logic [7:0] e_led;
    logic [7:0] e_oe;
    logic       e_rs;
    logic       e_en;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{8'h04, 8'h10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'hA5, 8'hA5, 8'hA5, 8'h00, 1'b0, 1'b0},
    '{8'h04, 8'h14, 8'hA5, 8'hA5, 8'hFF, 1'b0, 1'b0},
    '{8'h04, 8'h07, 8'hA5, 8'h00, 8'hFF, 1'b1, 1'b1},
    '{8'h00, 8'h3C, 8'h3C, 8'h00, 8'hFF, 1'b1, 1'b1},
    '{8'h04, 8'hF2, 8'h3C, 8'h3C, 8'h00, 1'b1, 1'b0},
    '{8'h08, 8'hFF, 8'h3C, 8'h3C, 8'h00, 1'b1, 1'b0},
    '{8'h04, 8'h01, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // read within one low phase; rdata is combinational
  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] ctrl_exp;
    ctrl_exp = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 pa_oe in reset", pa_oe, 8'h00);
    check("R1 led in reset", led, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pa_out after reset", pa_out, 8'h00);
    check("R1 disp lines after reset", {6'd0, disp_rs, disp_en}, 8'h00);
    bus_read(8'h04, rv);
    check("R1 ctrl readback after reset", rv, 8'h00);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      bus_write(VT[i].ofs, VT[i].wd);
      if (VT[i].ofs == 8'h04) ctrl_exp = VT[i].wd & 8'h17;
      check("R3 pa_out", pa_out, VT[i].e_pa);
      check("R4 led", led, VT[i].e_led);
      check("R3 pa_oe", pa_oe, VT[i].e_oe);
      check("R5 disp_rs/disp_en", {6'd0, disp_rs, disp_en}, {6'd0, VT[i].e_rs, VT[i].e_en});
      bus_read(8'h04, rv);
      check("R2 ctrl readback", rv, ctrl_exp);
    end

    // R9: idle bus reads zero
    bus_addr = 8'h04; #1;
    check("R9 rdata idle", bus_rdata, 8'h00);

    // R8: undecoded reads
    bus_read(8'h08, rv); check("R8 read 0x08", rv, 8'h00);
    bus_read(8'h01, rv); check("R8 read 0x01", rv, 8'h00);
    bus_read(8'hFC, rv); check("R8 read 0xFC", rv, 8'h00);

    // R7: input mode, synchronizer latency
    bus_write(8'h04, 8'h00);
    pa_in = 8'h00;
    repeat (3) @(negedge clk);
    pa_in = 8'h5A;
    bus_read(8'h00, rv); check("R7 zero edges", rv, 8'h00);
    @(negedge clk);
    bus_read(8'h00, rv); check("R7 one edge", rv, 8'h00);
    @(negedge clk);
    bus_read(8'h00, rv); check("R7 two edges", rv, 8'h5A);
    pa_in = 8'hC3;
    repeat (2) @(negedge clk);
    bus_read(8'h00, rv); check("R7 second pattern", rv, 8'hC3);

    // R6: output mode reads the latch, not the pins
    bus_write(8'h00, 8'h69);
    bus_write(8'h04, 8'h04);
    bus_read(8'h00, rv); check("R6 output readback", rv, 8'h69);
    check("R3 pa_oe output mode", pa_oe, 8'hFF);
    check("R4 led dark bit4=0", led, 8'h00);

    // R1: mid-run reset clears all
    bus_write(8'h04, 8'h17);
    check("R4 led lit", led, 8'h69);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset pa_out", pa_out, 8'h00);
    check("R1 mid reset pa_oe", pa_oe, 8'h00);
    check("R1 mid reset led", led, 8'h00);
    check("R1 mid reset disp", {6'd0, disp_rs, disp_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'h04, rv); check("R1 ctrl after mid reset", rv, 8'h00);

    finish_run();
  end
endmodule